// File: doc/BRIEF.md
# Fault Event Recorder

The recorder keeps a log of supervisory snapshots in a small nonvolatile array. Each time the sequencing controller enters a state that is marked for logging, it offers a snapshot: the full status word plus a flag that shows whether the chip runs from its high-voltage supply input. The recorder turns each snapshot into an 8-byte record and programs it, one byte at a time, into the next free slot of a fixed 16-slot region. The array is modelled on chip as 32 pages of 32 bytes. A page can only be erased as a whole, and programming can only clear bits, so a byte must be erased before it takes new data.

The slot pointer is not held in a register that survives power loss. After every reset the recorder scans the marker byte of each slot and resumes at the first slot that still reads erased. Once all 16 slots are used, further snapshots are taken and dropped, and the full flag stays high. A clear command erases the pages that hold the records and sets the pointer back to slot 0. A host read port returns any byte of the array.

Snapshots enter through a valid/ready port. A snapshot that arrives while a record is being written waits in a one-entry queue. `snap_ready` drops only while that entry is occupied, and the producer must then hold `snap_valid` and its data. Host reads also use valid/ready. A request is taken when `rd_valid` and `rd_ready` are both high. The byte comes back on `rsp_data` with `rsp_valid` in the next cycle and is held until `rsp_ready` is high.

Top module: `fault_recorder`

## Requirements
- R1: After reset, `busy` is high and `rd_ready` is low while the recorder scans the marker byte (byte 0) of slots 0 to 15 in order. `rec_count` becomes the index of the first slot whose marker reads 0xFF, or 16 when no marker does. Array contents are not altered by reset.
- R2: An accepted snapshot is written to slot `rec_count`, and `rec_count` then increments. Byte 0 of the record holds `snap_hv` in bit 0 with every other bit 0. Bytes 1 to 7 hold `snap_status`, least significant byte first. Byte j of slot k lives at array offset 384 + 8k + j, which is absolute address 0xF980 + 8k + j on a 0xF800 base.
- R3: The recorder holds at most one waiting snapshot. `snap_ready` is low only while that entry is occupied. Snapshots are recorded in the order they are accepted.
- R4: With 16 records stored, `full` is high and `snap_ready` stays high. Snapshots are accepted and discarded, leaving `rec_count` and the array unchanged.
- R5: A `clr` pulse while `busy` is low erases the four record pages (every byte reads 0xFF), keeps `busy` high for at least 4 × ERASE_CYC cycles, and returns `rec_count` to 0 with `full` low. A `clr` pulse while `busy` is high is ignored.
- R6: Each byte program occupies the array for PROG_CYC cycles. `busy` stays high from the cycle after a snapshot leaves the queue until its last byte is done, so it is still high 8 × PROG_CYC cycles after acceptance.
- R7: A host request is accepted when `rd_valid` and `rd_ready` are both high. In the next cycle `rsp_valid` rises with the byte at `rd_addr`. It stays valid and stable until `rsp_ready` is high, and `rd_ready` is low while a response is held.
- R8: When `clr` and a snapshot arrive in the same idle cycle, the erase runs first. The snapshot is then recorded in slot 0, leaving `rec_count` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Snapshot can be taken |
| snap_status | input | 56 | Status word to record |
| snap_hv | input | 1 | Chip powered from high-voltage input |
| clr | input | 1 | Erase all records (pulse, idle only) |
| rd_valid | input | 1 | Host read request |
| rd_ready | output | 1 | Host read request can be taken |
| rd_addr | input | 10 | Byte offset into the array |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | 8 | Read data byte |
| busy | output | 1 | Scan, erase or program in progress |
| full | output | 1 | All 16 slots used |
| rec_count | output | 5 | Number of stored records (next free slot) |

## Verification
The clear command and a new snapshot can arrive in the same idle cycle. The bench provokes this by raising `clr` and `snap_valid` on the same edge. It then expects an erased region with that snapshot alone in slot 0 and a count of 1. A clear that lands while a record is being programmed is also driven, and is judged by checking that the count and the record bytes read back unchanged.

// File: rtl/frec_pkg.sv
package frec_pkg;
  typedef enum logic [1:0] {ST_SCAN, ST_IDLE, ST_PROG, ST_ERASE} rec_state_e;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/frec_nvarray.sv
module frec_nvarray #(
  parameter int PAGES      = 32,
  parameter int PAGE_BYTES = 32,
  parameter int ERASE_CYC  = 20,
  parameter int PROG_CYC   = 4,
  localparam int DEPTH = PAGES * PAGE_BYTES,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_erase,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  output logic          busy,
  output logic          done,
  input  logic [AW-1:0] ra_addr,
  output logic [7:0]    ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [7:0]    rb_data
);
  import frec_pkg::*;
  localparam int OW   = $clog2(PAGE_BYTES);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt;
  logic          op_erase;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;

  // shipped state of the cells: everything erased
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = ERASED_BYTE;
  end

  assign busy    = (cnt != '0);
  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      done     <= 1'b0;
      op_erase <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      done <= 1'b0;
      if (cnt == '0) begin
        if (cmd_valid) begin
          cnt      <= cmd_erase ? CW'(ERASE_CYC) : CW'(PROG_CYC);
          op_erase <= cmd_erase;
          op_addr  <= cmd_addr;
          op_data  <= cmd_data;
        end
      end else if (cnt == CW'(1)) begin
        cnt  <= '0;
        done <= 1'b1;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  // cell update: no reset, contents persist across rst_n
  always_ff @(posedge clk) begin
    if (cnt == CW'(1)) begin
      if (op_erase) begin
        for (int o = 0; o < PAGE_BYTES; o++)
          mem[{op_addr[AW-1:OW], OW'(o)}] <= ERASED_BYTE;
      end else begin
        mem[op_addr] <= mem[op_addr] & op_data;
      end
    end
  end

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/frec_snapq.sv
module frec_snapq #(
  parameter int STAT_W = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [STAT_W-1:0] in_status,
  input  logic              in_hv,
  input  logic              pop,
  output logic              q_valid,
  output logic [STAT_W-1:0] q_status,
  output logic              q_hv
);
  assign in_ready = !q_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_status <= '0;
      q_hv     <= 1'b0;
    end else if (in_valid && in_ready) begin
      q_valid  <= 1'b1;
      q_status <= in_status;
      q_hv     <= in_hv;
    end else if (pop) begin
      q_valid <= 1'b0;
    end
  end

  // R3
  queue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !pop) |=> (q_valid && $stable(q_status) && $stable(q_hv)));
endmodule

// File: rtl/frec_ctrl.sv
module frec_ctrl #(
  parameter int SLOTS      = 16,
  parameter int REC_BYTES  = 8,
  parameter int PAGE_BYTES = 32,
  parameter int BASE_OFF   = 384,
  parameter int AW         = 10,
  localparam int STAT_W = (REC_BYTES - 1) * 8,
  localparam int SW     = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              q_valid,
  input  logic [STAT_W-1:0] q_status,
  input  logic              q_hv,
  output logic              q_pop,
  input  logic              arr_busy,
  input  logic              arr_done,
  output logic              cmd_valid,
  output logic              cmd_erase,
  output logic [AW-1:0]     cmd_addr,
  output logic [7:0]        cmd_data,
  output logic [AW-1:0]     scan_addr,
  input  logic [7:0]        scan_data,
  output logic              scanning,
  output logic              busy,
  output logic              full,
  output logic [SW-1:0]     count
);
  import frec_pkg::*;
  localparam int REC_PAGES = (SLOTS * REC_BYTES + PAGE_BYTES - 1) / PAGE_BYTES;
  localparam int IW        = $clog2(SLOTS + REC_BYTES + REC_PAGES + 1);

  rec_state_e              st;
  logic [SW-1:0]           ptr;
  logic [IW-1:0]           idx;
  logic                    wait_q;
  logic [REC_BYTES*8-1:0]  rec_buf;

  assign count     = ptr;
  assign full      = (ptr == SW'(SLOTS));
  assign scanning  = (st == ST_SCAN);
  assign busy      = (st != ST_IDLE) || arr_busy;
  assign q_pop     = (st == ST_IDLE) && q_valid && !clr;
  assign cmd_valid = ((st == ST_PROG) || (st == ST_ERASE)) && !wait_q;
  assign cmd_erase = (st == ST_ERASE);
  assign cmd_data  = rec_buf[int'(idx)*8 +: 8];
  assign scan_addr = AW'(BASE_OFF + int'(idx) * REC_BYTES);
  assign cmd_addr  = (st == ST_ERASE) ? AW'(BASE_OFF + int'(idx) * PAGE_BYTES)
                                      : AW'(BASE_OFF + int'(ptr) * REC_BYTES + int'(idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_SCAN;
      ptr     <= '0;
      idx     <= '0;
      wait_q  <= 1'b0;
      rec_buf <= '0;
    end else begin
      unique case (st)
        ST_SCAN: begin
          if (scan_data == ERASED_BYTE) begin
            ptr <= SW'(idx);
            st  <= ST_IDLE;
          end else if (idx == IW'(SLOTS - 1)) begin
            ptr <= SW'(SLOTS);
            st  <= ST_IDLE;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        ST_IDLE: begin
          idx    <= '0;
          wait_q <= 1'b0;
          if (clr) begin
            st <= ST_ERASE;
          end else if (q_valid && (ptr != SW'(SLOTS))) begin
            rec_buf <= {q_status, 7'b0, q_hv};
            st      <= ST_PROG;
          end
        end
        ST_PROG: begin
          if (!wait_q) begin
            wait_q <= 1'b1;
          end else if (arr_done) begin
            wait_q <= 1'b0;
            if (idx == IW'(REC_BYTES - 1)) begin
              ptr <= ptr + SW'(1);
              st  <= ST_IDLE;
            end else begin
              idx <= idx + IW'(1);
            end
          end
        end
        ST_ERASE: begin
          if (!wait_q) begin
            wait_q <= 1'b1;
          end else if (arr_done) begin
            wait_q <= 1'b0;
            if (idx == IW'(REC_PAGES - 1)) begin
              ptr <= '0;
              st  <= ST_IDLE;
            end else begin
              idx <= idx + IW'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6
  no_cmd_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !arr_busy);
  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && full && !clr) |=> full);
endmodule

// File: rtl/fault_recorder.sv
module fault_recorder #(
  parameter int SLOTS      = 16,
  parameter int REC_BYTES  = 8,
  parameter int PAGES      = 32,
  parameter int PAGE_BYTES = 32,
  parameter int BASE_OFF   = 384,
  parameter int ERASE_CYC  = 20,
  parameter int PROG_CYC   = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 snap_valid,
  output logic                                 snap_ready,
  input  logic [(REC_BYTES-1)*8-1:0]           snap_status,
  input  logic                                 snap_hv,
  input  logic                                 clr,
  input  logic                                 rd_valid,
  output logic                                 rd_ready,
  input  logic [$clog2(PAGES*PAGE_BYTES)-1:0]  rd_addr,
  output logic                                 rsp_valid,
  input  logic                                 rsp_ready,
  output logic [7:0]                           rsp_data,
  output logic                                 busy,
  output logic                                 full,
  output logic [$clog2(SLOTS+1)-1:0]           rec_count
);
  localparam int AW     = $clog2(PAGES * PAGE_BYTES);
  localparam int STAT_W = (REC_BYTES - 1) * 8;

  logic              q_valid, q_hv, q_pop;
  logic [STAT_W-1:0] q_status;
  logic              arr_busy, arr_done;
  logic              cmd_valid, cmd_erase;
  logic [AW-1:0]     cmd_addr, scan_addr;
  logic [7:0]        cmd_data, scan_data, host_data;
  logic              scanning;

  frec_snapq #(.STAT_W(STAT_W)) u_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(snap_valid), .in_ready(snap_ready),
    .in_status(snap_status), .in_hv(snap_hv),
    .pop(q_pop), .q_valid(q_valid), .q_status(q_status), .q_hv(q_hv)
  );

  frec_ctrl #(
    .SLOTS(SLOTS), .REC_BYTES(REC_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .BASE_OFF(BASE_OFF), .AW(AW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .q_valid(q_valid), .q_status(q_status), .q_hv(q_hv), .q_pop(q_pop),
    .arr_busy(arr_busy), .arr_done(arr_done),
    .cmd_valid(cmd_valid), .cmd_erase(cmd_erase), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .scan_addr(scan_addr), .scan_data(scan_data),
    .scanning(scanning), .busy(busy), .full(full), .count(rec_count)
  );

  frec_nvarray #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES),
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
  ) u_arr (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_erase(cmd_erase), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .busy(arr_busy), .done(arr_done),
    .ra_addr(scan_addr), .ra_data(scan_data),
    .rb_addr(rd_addr), .rb_data(host_data)
  );

  assign rd_ready = !scanning && (!rsp_valid || rsp_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_valid && rd_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= host_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/fault_recorder_bench.sv
module fault_recorder_bench;
  localparam int SLOTS = 16, RB = 8, BASE = 384, ERASE_CYC = 20, PROG_CYC = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        snap_valid = 1'b0, snap_hv = 1'b0, clr = 1'b0;
  logic [55:0] snap_status = '0;
  logic        snap_ready;
  logic        rd_valid = 1'b0, rsp_ready = 1'b0;
  logic [9:0]  rd_addr = '0;
  logic        rd_ready, rsp_valid, busy, full;
  logic [7:0]  rsp_data;
  logic [4:0]  rec_count;

  int checks = 0, errors = 0, cycles = 0;
  bit done_flag = 0;
  logic [7:0] exp_mem [SLOTS*RB];
  int exp_count = 0;

  fault_recorder u_fault_recorder (
    .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid), .snap_ready(snap_ready),
    .snap_status(snap_status), .snap_hv(snap_hv), .clr(clr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .full(full), .rec_count(rec_count)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done_flag) begin
      done_flag = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] rec_byte(logic [55:0] s, logic hv, int j);
    return (j == 0) ? {7'b0, hv} : s[8*(j-1) +: 8];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_erase();
    for (int i = 0; i < SLOTS*RB; i++) exp_mem[i] = 8'hFF;
    exp_count = 0;
  endtask

  task automatic model_rec(logic [55:0] s, logic hv);
    if (exp_count < SLOTS) begin
      for (int j = 0; j < RB; j++) exp_mem[exp_count*RB + j] = rec_byte(s, hv, j);
      exp_count++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || !snap_ready) @(negedge clk);
  endtask

  task automatic push(logic [55:0] s, logic hv, bit time_check);
    @(negedge clk);
    while (!snap_ready) @(negedge clk);
    snap_valid = 1'b1; snap_status = s; snap_hv = hv;
    model_rec(s, hv);
    @(negedge clk);
    snap_valid = 1'b0;
    if (time_check) begin
      repeat (RB*PROG_CYC - 1) @(negedge clk);
      chk(busy == 1'b1, "R6 busy during program", busy, 1);
    end
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    rd_valid = 1'b1; rd_addr = 10'(a);
    @(negedge clk);
    rd_valid = 1'b0;
    d = rsp_data;
    chk(rsp_valid == 1'b1, "R7 rsp_valid after request", rsp_valid, 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic check_slot(int k, string tag);
    logic [7:0] d;
    for (int j = 0; j < RB; j++) begin
      rd(BASE + k*RB + j, d);
      chk(d == exp_mem[k*RB + j], tag, d, exp_mem[k*RB + j]);
    end
  endtask

  task automatic random_snap(bit tc);
    logic [55:0] s;
    s = {24'($urandom), 32'($urandom)};
    push(s, 1'($urandom), tc);
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] held;
    void'($urandom(32'd7321));
    model_erase();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: scan in progress right after reset
    chk(busy == 1'b1, "R1 busy during scan", busy, 1);
    chk(rd_ready == 1'b0, "R1 rd_ready low during scan", rd_ready, 0);
    wait_idle();
    chk(rec_count == 5'd0, "R1 count on empty array", rec_count, 0);
    chk(full == 1'b0, "R1 full low on empty array", full, 0);

    // R2 / R6: first record with timing check
    random_snap(1'b1);
    wait_idle();
    chk(rec_count == 5'(exp_count), "R2 count after record", rec_count, exp_count);
    check_slot(0, "R2 slot0 bytes");

    // R3: back-to-back snapshots, second waits in the queue
    random_snap(1'b0);
    random_snap(1'b0);
    @(negedge clk);
    chk(snap_ready == 1'b0, "R3 ready low with queued entry", snap_ready, 0);
    wait_idle();
    chk(rec_count == 5'(exp_count), "R3 count after queued pair", rec_count, exp_count);
    check_slot(1, "R3 slot1 order");
    check_slot(2, "R3 slot2 order");

    for (int i = 0; i < 4; i++) random_snap(1'b0);
    wait_idle();
    check_slot(6, "R2 slot6 bytes");

    // R7: back-pressure on the response
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    rd_valid = 1'b1; rd_addr = 10'(BASE + 6*RB + 3);
    @(negedge clk);
    rd_valid = 1'b0;
    held = rsp_data;
    repeat (2) @(negedge clk);
    chk(rsp_valid == 1'b1, "R7 rsp held", rsp_valid, 1);
    chk(rsp_data == held && held == exp_mem[6*RB+3], "R7 rsp data stable", rsp_data, exp_mem[6*RB+3]);
    chk(rd_ready == 1'b0, "R7 rd_ready low while held", rd_ready, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;

    // R1: reset rebuilds pointer, contents survive
    do_reset();
    wait_idle();
    chk(rec_count == 5'(exp_count), "R1 count rebuilt after reset", rec_count, exp_count);
    check_slot(4, "R1 slot4 survives reset");

    // R4: fill up, then overflow is dropped
    while (exp_count < SLOTS) random_snap(1'b0);
    wait_idle();
    chk(full == 1'b1, "R4 full raised", full, 1);
    chk(rec_count == 5'd16, "R4 count at 16", rec_count, 16);
    @(negedge clk);
    chk(snap_ready == 1'b1, "R4 ready high when full", snap_ready, 1);
    random_snap(1'b0);
    wait_idle();
    chk(rec_count == 5'd16, "R4 count unchanged", rec_count, 16);
    check_slot(15, "R4 slot15 untouched");

    do_reset();
    wait_idle();
    chk(rec_count == 5'd16 && full, "R1 scan finds all used", rec_count, 16);

    // R5: clear
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model_erase();
    repeat (4*ERASE_CYC - 1) @(negedge clk);
    chk(busy == 1'b1, "R5 busy during erase", busy, 1);
    wait_idle();
    chk(rec_count == 5'd0, "R5 count reset", rec_count, 0);
    chk(full == 1'b0, "R5 full cleared", full, 0);
    for (int k = 0; k < SLOTS; k++) check_slot(k, "R5 region erased");

    // R5: clear while busy is ignored
    random_snap(1'b0);
    repeat (3) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    wait_idle();
    chk(rec_count == 5'(exp_count), "R5 clr ignored while busy", rec_count, exp_count);
    check_slot(0, "R5 record kept");

    // R8: clear and snapshot in the same idle cycle
    @(negedge clk);
    clr = 1'b1; snap_valid = 1'b1;
    snap_status = {24'($urandom), 32'($urandom)}; snap_hv = 1'b1;
    model_erase();
    model_rec(snap_status, snap_hv);
    @(negedge clk);
    clr = 1'b0; snap_valid = 1'b0;
    wait_idle();
    chk(rec_count == 5'd1, "R8 count after clr+snap", rec_count, 1);
    check_slot(0, "R8 slot0 holds snapshot");
    check_slot(1, "R8 slot1 erased");

    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule